// File: doc/BRIEF.md
# Display Receiver Hot-Plug Detect Controller

This block drives the hot-plug detect level of one display receiver port. The level goes high only when three things hold: the cable's 5 V supply is present, the port is the active input, and the EDID store reports that its content can be read. A source reads the EDID over the display data channel only after it sees the hot-plug level rise. If the level rises before the EDID is readable, the source treats the receiver as a video-only monitor. If the level stays low, the source cannot read the EDID at all.

The EDID can change, or the port can become the active input again. In either case the controller pulls the level low for a minimum time, then lets it rise again so that the source reads the EDID anew. The minimum time is a cycle count derived from the system clock frequency. By default it is 110 ms, which is 100 ms plus a 10 % margin. An EDID-change pulse that arrives while the forced low is running starts the timer again. Loss of 5 V drops the level on the next clock.

The EDID-change and port-select inputs may come from another clock domain. Each passes through two flip-flops before use. The 5 V detect, EDID-ready and soft-reset inputs must already be synchronous to the system clock. The controller state is visible on a two-bit status port.

Top module: `hpd_sink_ctrl`

## Requirements
- R1: `hpd_o` is high in a cycle only if `edid_ready_i` was high in the previous cycle. `hpd_o` rises only out of the waiting state (1) or the forced-low state (3).
- R2: When `pwr5v_i` is low at a clock edge, `hpd_o` is 0 and `status_o` is 0 (idle-low) from that edge on. When 5 V returns with the port selected and no new selection edge, the status goes to 1 (waiting for EDID) after one edge. `hpd_o` rises on the edge after `edid_ready_i` is seen high.
- R3: A rising edge on `edid_chg_i` while `hpd_o` is high drives `hpd_o` low exactly 3 clock edges after the edge on which it is first sampled. Two of those edges are the synchroniser and one is the state register.
- R4: With 5 V present, a rising edge on `port_sel_i` puts the controller in forced-low (status 3) 3 edges after it is sampled. A falling edge on `port_sel_i` puts it in idle-low (status 0) 3 edges after it is sampled.
- R5: A forced-low interval with no further events lasts exactly LOW_CYC = CLK_HZ * LOW_US / 1,000,000 cycles.
- R6: An EDID-change edge during a forced-low interval restarts the timer. If the second change is sampled d cycles after the first, the total low time is d + LOW_CYC cycles.
- R7: If `edid_ready_i` is low when the forced-low interval ends, the status goes to 1 (waiting) and `hpd_o` stays low. `hpd_o` rises on the edge after `edid_ready_i` is seen high.
- R8: `edid_ready_i` going low while `hpd_o` is high starts a full forced-low interval: status 3 and `hpd_o` low after one edge.
- R9: `soft_rst_i` high at an edge puts the controller in status 0 with `hpd_o` low. After it is released with 5 V present and the port selected, the status goes to 1 and then to 2 on the next two edges, provided `edid_ready_i` is high.
- R10: The status codes are 0 = idle-low, 1 = waiting for EDID, 2 = hot-plug high and 3 = forced-low. `hpd_o` is high exactly in status 2. While `rst_ni` is low, the status is 0 and `hpd_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; the timebase for the low interval |
| rst_ni | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous return to idle-low |
| pwr5v_i | input | 1 | Cable 5 V present, synchronous |
| edid_ready_i | input | 1 | EDID store readable, synchronous |
| edid_chg_i | input | 1 | EDID content changed; a rising edge is an event; asynchronous |
| port_sel_i | input | 1 | This port is the active input; asynchronous |
| hpd_o | output | 1 | Hot-plug detect level toward the analog drive stage |
| status_o | output | 2 | Controller state code (see R10) |

## Verification
The hardest case to reach is a second EDID change that lands inside a forced-low interval that is already running. Hitting it needs the change to arrive after the first change has passed the synchroniser and before the timer expires. The bench counts falling clock edges from the first change pulse. It places the second pulse a random number of cycles into the low interval and predicts the total low time as that distance plus the nominal interval. The bench also drops EDID-ready while the level is high, and it removes 5 V and soft-resets the block with EDID-ready held. These reach every exit from the high state.

// File: rtl/hpdc_pkg.sv
package hpdc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE_LOW   = 2'd0,
    ST_WAIT_EDID  = 2'd1,
    ST_HIGH       = 2'd2,
    ST_FORCED_LOW = 2'd3
  } hpd_state_e;

  // Cycles of the minimum low interval for a given clock rate and length in microseconds.
  function automatic int unsigned low_cycles(input longint unsigned clk_hz,
                                             input longint unsigned low_us);
    longint unsigned c;
    c = (clk_hz * low_us) / 64'd1000000;
    if (c == 0) c = 1;
    return int'(c[31:0]);
  endfunction

endpackage

// File: rtl/hpdc_sync.sv
module hpdc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hpdc_edge.sv
module hpdc_edge #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rise_o[i] = lvl_i[i] & ~prev_q[i];
    assign fall_o[i] = ~lvl_i[i] & prev_q[i];
  end
endmodule

// File: rtl/hpdc_timer.sv
module hpdc_timer #(
  parameter int unsigned CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  localparam int TW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [TW-1:0] LOAD_VAL = TW'(CYC - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/hpdc_fsm.sv
module hpdc_fsm
  import hpdc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       soft_rst_i,
  input  logic       pwr_i,
  input  logic       sel_i,
  input  logic       ready_i,
  input  logic       chg_evt_i,
  input  logic       sw_evt_i,
  input  logic       tmr_done_i,
  output logic       tmr_load_o,
  output hpd_state_e state_o
);
  hpd_state_e state_q, state_d;
  logic       restart;

  assign restart = chg_evt_i | sw_evt_i;

  always_comb begin
    state_d = state_q;
    if (soft_rst_i || !pwr_i || !sel_i) begin
      state_d = ST_IDLE_LOW;
    end else begin
      unique case (state_q)
        ST_IDLE_LOW:   state_d = restart ? ST_FORCED_LOW : ST_WAIT_EDID;
        ST_WAIT_EDID:  state_d = restart ? ST_FORCED_LOW :
                                 (ready_i ? ST_HIGH : ST_WAIT_EDID);
        ST_HIGH:       state_d = (restart || !ready_i) ? ST_FORCED_LOW : ST_HIGH;
        ST_FORCED_LOW: begin
          if (restart)         state_d = ST_FORCED_LOW;
          else if (tmr_done_i) state_d = ready_i ? ST_HIGH : ST_WAIT_EDID;
          else                 state_d = ST_FORCED_LOW;
        end
        default:       state_d = ST_IDLE_LOW;
      endcase
    end
  end

  assign tmr_load_o = (state_d == ST_FORCED_LOW) &&
                      ((state_q != ST_FORCED_LOW) || restart);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE_LOW;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/hpd_sink_ctrl.sv
module hpd_sink_ctrl
  import hpdc_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 200_000_000,
  parameter int unsigned LOW_US      = 110_000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       soft_rst_i,
  input  logic       pwr5v_i,
  input  logic       edid_ready_i,
  input  logic       edid_chg_i,
  input  logic       port_sel_i,
  output logic       hpd_o,
  output logic [1:0] status_o
);
  localparam int unsigned LOW_CYC = low_cycles(64'(CLK_HZ), 64'(LOW_US));
  localparam int          NSYNC   = 2;   // bit 0: EDID change, bit 1: port select

  logic [NSYNC-1:0] async_lvl, sync_lvl, rise, fall;
  logic             tmr_load, tmr_done;
  hpd_state_e       state;

  assign async_lvl = {port_sel_i, edid_chg_i};

  hpdc_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (async_lvl),
    .q_o   (sync_lvl)
  );

  hpdc_edge #(.W(NSYNC)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (sync_lvl),
    .rise_o(rise),
    .fall_o(fall)
  );

  hpdc_timer #(.CYC(LOW_CYC)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .done_o(tmr_done)
  );

  hpdc_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_rst_i(soft_rst_i),
    .pwr_i     (pwr5v_i),
    .sel_i     (sync_lvl[1]),
    .ready_i   (edid_ready_i),
    .chg_evt_i (rise[0]),
    .sw_evt_i  (rise[1]),
    .tmr_done_i(tmr_done),
    .tmr_load_o(tmr_load),
    .state_o   (state)
  );

  // Falling edges are not used by the controller; the level itself returns the state to idle.
  logic unused_fall;
  assign unused_fall = ^fall;

  assign hpd_o    = (state == ST_HIGH);
  assign status_o = state;
endmodule

// File: rtl/hpd_sink_ctrl_chk.sv
module hpd_sink_ctrl_chk
  import hpdc_pkg::*;
#(
  parameter int unsigned CLK_HZ = 200_000_000,
  parameter int unsigned LOW_US = 110_000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       soft_rst_i,
  input logic       pwr5v_i,
  input logic       edid_ready_i,
  input logic       hpd_o,
  input logic [1:0] status_o
);
  localparam int unsigned LOW_CYC = low_cycles(64'(CLK_HZ), 64'(LOW_US));

  logic [31:0] low_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              low_len_q <= '0;
    else if (status_o == 2'd3) low_len_q <= low_len_q + 1'b1;
    else                      low_len_q <= '0;
  end

  // R1
  a_r1_high_needs_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hpd_o |-> $past(edid_ready_i));

  // R1
  a_r1_rise_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hpd_o) |-> ($past(status_o) == 2'd1 || $past(status_o) == 2'd3));

  // R2
  a_r2_power_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr5v_i |=> (!hpd_o && status_o == 2'd0));

  // R5
  a_r5_min_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(status_o) == 2'd3 && (status_o == 2'd1 || status_o == 2'd2))
      |-> (low_len_q >= LOW_CYC));

  // R9
  a_r9_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (status_o == 2'd0 && !hpd_o));

endmodule

bind hpd_sink_ctrl hpd_sink_ctrl_chk #(.CLK_HZ(CLK_HZ), .LOW_US(LOW_US)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .soft_rst_i  (soft_rst_i),
  .pwr5v_i     (pwr5v_i),
  .edid_ready_i(edid_ready_i),
  .hpd_o       (hpd_o),
  .status_o    (status_o)
);

// File: tb/hpd_sink_ctrl_test.sv
`timescale 1ns/1ps
module hpd_sink_ctrl_test;
  localparam int unsigned CLK_HZ = 1_000_000;
  localparam int unsigned LOW_US = 150;

  logic clk = 1'b0;
  logic rst_n, soft_rst, pwr, ready, chg, sel;
  logic hpd;
  logic [1:0] status;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hpd_sink_ctrl #(.CLK_HZ(CLK_HZ), .LOW_US(LOW_US)) uut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .pwr5v_i(pwr),
    .edid_ready_i(ready), .edid_chg_i(chg), .port_sel_i(sel),
    .hpd_o(hpd), .status_o(status)
  );

  function automatic int exp_low(input int unsigned hz, input int unsigned us);
    longint unsigned c;
    c = (64'(hz) * 64'(us)) / 64'd1000000;
    return (c == 0) ? 1 : int'(c);
  endfunction

  function automatic int exp_restart(input int d);
    return d + exp_low(CLK_HZ, LOW_US);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Count the negedge samples with hpd low, starting at the current sample.
  task automatic count_low(output int n);
    n = 0;
    while (!hpd && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // Count the negedge samples spent in forced-low, starting at the current sample.
  task automatic count_forced(output int n);
    n = 0;
    while (status == 2'd3 && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n, t, w, g, d, low;
    bit seen_low;
    void'($urandom(32'd4242));
    rst_n = 0; soft_rst = 0; pwr = 1; ready = 0; chg = 0; sel = 1;
    step(3);
    chk("R10 reset status", status, 0);
    chk("R10 reset hpd", hpd, 0);
    rst_n = 1;
    step(3);
    chk("R4 select edge after reset gives forced-low", status, 3);
    count_forced(n);
    chk("R5 forced-low length", n, exp_low(CLK_HZ, LOW_US));
    chk("R7 waits when EDID not ready", status, 1);
    chk("R7 hpd low while waiting", hpd, 0);
    ready = 1;
    step(1);
    chk("R7 hpd rises one edge after ready", hpd, 1);
    chk("R10 high status", status, 2);

    // R3 / R5: EDID change pulses of random width
    for (int k = 0; k < 4; k++) begin
      w = 1 + ($urandom % 3);
      chg = 1; t = 0;
      while (hpd && t < 10) begin
        @(negedge clk); t++;
        if (t == w) chg = 0;
      end
      chg = 0;
      chk("R3 change-to-low latency", t, 3);
      count_low(n);
      chk("R5 low length after change", n, exp_low(CLK_HZ, LOW_US));
      step(2 + ($urandom % 5));
    end

    // R6: second change inside the forced-low interval
    for (int k = 0; k < 3; k++) begin
      g = 2 + ($urandom % (exp_low(CLK_HZ, LOW_US) - 12));
      d = 3 + g;
      chg = 1; t = 0; low = 0; seen_low = 0;
      while (t < 20000) begin
        @(negedge clk); t++;
        if (t == 1) chg = 0;
        if (!hpd) begin low++; seen_low = 1; end
        else if (seen_low) break;
        if (t == d) chg = 1;
        if (t == d + 1) chg = 0;
      end
      chk("R6 restarted low length", low, exp_restart(d));
      step(3);
    end

    // R8: ready drops while high
    ready = 0;
    step(1);
    chk("R8 forced-low after ready loss", status, 3);
    chk("R8 hpd low after ready loss", hpd, 0);
    count_forced(n);
    chk("R8 full interval after ready loss", n, exp_low(CLK_HZ, LOW_US));
    chk("R7 waiting after interval", status, 1);
    ready = 1;
    step(1);
    chk("R1 high after ready", hpd, 1);

    // R2: 5 V loss and return
    pwr = 0;
    step(1);
    chk("R2 hpd low on power loss", hpd, 0);
    chk("R2 idle on power loss", status, 0);
    ready = 0;
    step(5);
    chk("R2 stays idle without power", status, 0);
    pwr = 1;
    step(1);
    chk("R2 waits for EDID on power return", status, 1);
    step(4);
    chk("R1 stays low without ready", hpd, 0);
    ready = 1;
    step(1);
    chk("R2 hpd high once ready", hpd, 1);

    // R4: deselect and reselect
    sel = 0;
    step(2);
    chk("R4 deselect not yet seen", status, 2);
    step(1);
    chk("R4 deselect gives idle", status, 0);
    chk("R4 hpd low when deselected", hpd, 0);
    step(3);
    sel = 1;
    step(3);
    chk("R4 reselect gives forced-low", status, 3);
    count_low(n);
    chk("R5 low after reselect", n, exp_low(CLK_HZ, LOW_US));
    chk("R4 high after reselect interval", status, 2);

    // R9: soft reset
    soft_rst = 1;
    step(1);
    chk("R9 soft reset idle", status, 0);
    chk("R9 soft reset hpd", hpd, 0);
    soft_rst = 0;
    step(1);
    chk("R9 waiting after release", status, 1);
    step(1);
    chk("R9 high after release", status, 2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule